// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block keeps the fetch address of a simple 32-bit load/store processor and works out, every clock, where the next instruction comes from. Instructions are four bytes long, so straight-line code steps the counter by four. Decoded control from the instruction in flight can redirect the flow in three ways. A conditional branch uses a signed word offset that is added to the address after the branch. A region jump replaces the low 28 bits of the counter and keeps the top four. A register jump loads a full address taken from a register.

The branch condition comes from the ALU zero flag, which the datapath sets by comparing the two source registers. A linking jump also presents a return address (the address after the jump), a write request, and the fixed index of the return-address register. A surrounding register file uses these to record where to return. A stall input freezes the counter and suppresses the link write. When several redirect requests arrive together, a fixed priority settles them. Reset is asynchronous and active low. Its release is synchronised inside the block, and the counter then starts from a parameterised reset vector.

Top module: `pc_branch_unit`

## Requirements
- R1: While reset is asserted, and until its synchronised release two clock edges after `rst_n` rises, `pc_o` equals `RESET_VEC` and `link_we_o` is 0.
- R2: With no stall and no control input active, the next `pc_o` is the current `pc_o` plus 4, wrapping modulo 2^32 (0xFFFFFFFC goes to 0).
- R3: A taken branch loads `pc_o + 4 + sign_extend(br_off_i) * 4`. Bit 15 of the offset is its sign.
- R4: A branch request is taken when `beq_i` is high and `zero_i` is 1, or when `bne_i` is high and `zero_i` is 0. Otherwise the PC falls through to `pc_o + 4`.
- R5: `jump_i` or `jal_i` loads a target whose bits 31:28 are the current `pc_o[31:28]`, bits 27:2 are `jfield_i`, and bits 1:0 are 0.
- R6: When `jal_i` is high (with no stall and no `jreg_i`), `link_we_o` is 1 and `link_addr_o` is the current `pc_o + 4`. `link_dst_o` is always 31.
- R7: `jreg_i` loads `jreg_val_i` into the PC unchanged, including its two low bits.
- R8: While `stall_i` is high, the PC keeps its value and `link_we_o` is 0, whatever the control inputs are.
- R9: Priority is `jreg_i` first, then `jump_i`/`jal_i`, then a taken branch, then sequential flow. When `jreg_i` and `jal_i` are both high, no link write is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Hold the PC and suppress the link write |
| beq_i | input | 1 | Branch if the compared registers are equal |
| bne_i | input | 1 | Branch if the compared registers differ |
| jump_i | input | 1 | Region jump |
| jal_i | input | 1 | Region jump that also saves the return address |
| jreg_i | input | 1 | Jump to a register value |
| zero_i | input | 1 | ALU zero flag (1 when the compared registers are equal) |
| br_off_i | input | 16 | Signed branch offset, counted in words |
| jfield_i | input | 26 | Word index of the jump target inside the current region |
| jreg_val_i | input | 32 | Register value used as the register-jump target |
| pc_o | output | 32 | Current fetch address |
| link_addr_o | output | 32 | Return address offered for the link write |
| link_we_o | output | 1 | Link write request |
| link_dst_o | output | 5 | Index of the return-address register (31) |

## Verification
The bench builds the block with the default widths (32-bit address, 16-bit offset, 26-bit jump field) and a reset vector of 0xBFC00000 instead of the default of 0. With that vector, the very first jumps already have nonzero region bits to keep, so a jump that drops or shifts the top four bits shows up at once. The vector is also easy to tell apart from a counter that was merely cleared. Directed cases cover:
- the most negative and most positive branch offsets;
- wrap-around at the top of the address space;
- an unaligned register-jump target;
- every priority collision.

Random control mixes with register jumps to random addresses spread the PC over all regions.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  // Source of the next fetch address, in rising priority order.
  typedef enum logic [1:0] {
    NXT_SEQ    = 2'd0,
    NXT_BRANCH = 2'd1,
    NXT_REGION = 2'd2,
    NXT_REG    = 2'd3
  } nxt_src_e;

  // Byte distance between consecutive instructions, as a power of two.
  localparam int unsigned WORD_SHIFT = 2;

endpackage

// File: rtl/pcu_rst_sync.sv
module pcu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pcu_target_gen.sv
module pcu_target_gen
  import pcu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned JF_W   = 26
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [JF_W-1:0]   jfield_i,
  output logic [ADDR_W-1:0] seq_addr_o,
  output logic [ADDR_W-1:0] br_addr_o,
  output logic [ADDR_W-1:0] region_addr_o
);

  localparam int unsigned EXT_W    = ADDR_W - OFF_W - WORD_SHIFT;
  localparam int unsigned REGION_W = ADDR_W - JF_W - WORD_SHIFT;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << WORD_SHIFT;

  logic [ADDR_W-1:0] off_bytes;

  // Sequential successor; it is also the base for branches and the link value (R2, R3, R6).
  assign seq_addr_o = pc_i + STEP;

  // Sign-extended word offset turned into a byte offset (R3).
  assign off_bytes = {{EXT_W{off_i[OFF_W-1]}}, off_i, {WORD_SHIFT{1'b0}}};
  assign br_addr_o = seq_addr_o + off_bytes;

  // Region jump keeps the top PC bits that the field does not cover (R5).
  generate
    if (REGION_W > 0) begin : g_region
      assign region_addr_o = {pc_i[ADDR_W-1 -: REGION_W], jfield_i, {WORD_SHIFT{1'b0}}};
    end else begin : g_flat
      assign region_addr_o = {jfield_i[ADDR_W-WORD_SHIFT-1:0], {WORD_SHIFT{1'b0}}};
    end
  endgenerate

endmodule

// File: rtl/pcu_select.sv
module pcu_select
  import pcu_pkg::*;
(
  input  logic     beq_i,
  input  logic     bne_i,
  input  logic     jump_i,
  input  logic     jal_i,
  input  logic     jreg_i,
  input  logic     zero_i,
  output nxt_src_e src_o,
  output logic     link_req_o
);

  logic br_taken;

  // Equal-compare taken on zero, unequal-compare taken on nonzero (R4).
  assign br_taken = (beq_i & zero_i) | (bne_i & ~zero_i);

  // Fixed priority: register jump, region jump, branch, sequential (R9).
  always_comb begin
    if (jreg_i) begin
      src_o = NXT_REG;
    end else if (jump_i | jal_i) begin
      src_o = NXT_REGION;
    end else if (br_taken) begin
      src_o = NXT_BRANCH;
    end else begin
      src_o = NXT_SEQ;
    end
  end

  // A link is requested only when the linking jump wins arbitration (R6, R9).
  assign link_req_o = jal_i & ~jreg_i;

endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
  import pcu_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       OFF_W     = 16,
  parameter int unsigned       JF_W      = 26,
  parameter int unsigned       REG_IDX_W = 5,
  parameter int unsigned       RA_INDEX  = 31,
  parameter int unsigned       SYNC_STG  = 2,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stall_i,
  input  logic                 beq_i,
  input  logic                 bne_i,
  input  logic                 jump_i,
  input  logic                 jal_i,
  input  logic                 jreg_i,
  input  logic                 zero_i,
  input  logic [OFF_W-1:0]     br_off_i,
  input  logic [JF_W-1:0]      jfield_i,
  input  logic [ADDR_W-1:0]    jreg_val_i,
  output logic [ADDR_W-1:0]    pc_o,
  output logic [ADDR_W-1:0]    link_addr_o,
  output logic                 link_we_o,
  output logic [REG_IDX_W-1:0] link_dst_o
);

  logic              core_rst_n;
  logic              pc_en;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;
  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] br_addr;
  logic [ADDR_W-1:0] region_addr;
  nxt_src_e          src;
  logic              link_req;

  pcu_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  pcu_target_gen #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .JF_W   (JF_W)
  ) u_target (
    .pc_i          (pc_q),
    .off_i         (br_off_i),
    .jfield_i      (jfield_i),
    .seq_addr_o    (seq_addr),
    .br_addr_o     (br_addr),
    .region_addr_o (region_addr)
  );

  pcu_select u_select (
    .beq_i      (beq_i),
    .bne_i      (bne_i),
    .jump_i     (jump_i),
    .jal_i      (jal_i),
    .jreg_i     (jreg_i),
    .zero_i     (zero_i),
    .src_o      (src),
    .link_req_o (link_req)
  );

  // Clock enable: a stall freezes the counter (R8).
  assign pc_en = ~stall_i;

  // Next-state selection.
  always_comb begin
    unique case (src)
      NXT_REG:    pc_d = jreg_val_i;   // R7
      NXT_REGION: pc_d = region_addr;  // R5
      NXT_BRANCH: pc_d = br_addr;      // R3
      default:    pc_d = seq_addr;     // R2
    endcase
  end

  // State register (R1).
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc_q <= RESET_VEC;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  assign pc_o        = pc_q;
  assign link_addr_o = seq_addr;
  assign link_we_o   = link_req & pc_en & core_rst_n;
  assign link_dst_o  = REG_IDX_W'(RA_INDEX);

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       OFF_W     = 16,
  parameter int unsigned       JF_W      = 26,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_rst_n,
  input logic              stall_i,
  input logic              beq_i,
  input logic              bne_i,
  input logic              jump_i,
  input logic              jal_i,
  input logic              jreg_i,
  input logic              zero_i,
  input logic [JF_W-1:0]   jfield_i,
  input logic [ADDR_W-1:0] jreg_val_i,
  input logic [ADDR_W-1:0] pc_o,
  input logic [ADDR_W-1:0] link_addr_o,
  input logic              link_we_o
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << (JF_W + 2)) - ADDR_W'(1);

  logic quiet;
  assign quiet = ~(beq_i | bne_i | jump_i | jal_i | jreg_i);

  p_reset_vec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst_n) |-> pc_o == RESET_VEC);

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!stall_i && quiet) |=> pc_o == $past(pc_o) + STEP);

  p_region_jump_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!stall_i && !jreg_i && (jump_i || jal_i)) |=>
      pc_o == (($past(pc_o) & ~LOW_MASK) | (ADDR_W'($past(jfield_i)) << 2)));

  p_link_value_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    link_we_o |-> link_addr_o == pc_o + STEP);

  p_reg_jump_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!stall_i && jreg_i) |=> pc_o == $past(jreg_val_i));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    stall_i |=> $stable(pc_o));

  p_stall_nolink_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    stall_i |-> !link_we_o);

  p_jreg_nolink_r9: assert property (@(posedge clk) disable iff (!core_rst_n)
    jreg_i |-> !link_we_o);

endmodule

bind pc_branch_unit pcu_checker #(
  .ADDR_W    (ADDR_W),
  .OFF_W     (OFF_W),
  .JF_W      (JF_W),
  .RESET_VEC (RESET_VEC)
) u_pcu_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .core_rst_n  (core_rst_n),
  .stall_i     (stall_i),
  .beq_i       (beq_i),
  .bne_i       (bne_i),
  .jump_i      (jump_i),
  .jal_i       (jal_i),
  .jreg_i      (jreg_i),
  .zero_i      (zero_i),
  .jfield_i    (jfield_i),
  .jreg_val_i  (jreg_val_i),
  .pc_o        (pc_o),
  .link_addr_o (link_addr_o),
  .link_we_o   (link_we_o)
);

// File: tb/tb_pc_branch_unit.sv
module tb_pc_branch_unit;

  localparam logic [31:0] RV = 32'hBFC0_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall_i, beq_i, bne_i, jump_i, jal_i, jreg_i, zero_i;
  logic [15:0] br_off_i;
  logic [25:0] jfield_i;
  logic [31:0] jreg_val_i;
  logic [31:0] pc_o;
  logic [31:0] link_addr_o;
  logic        link_we_o;
  logic [4:0]  link_dst_o;

  int          total = 0;
  int          bad   = 0;
  bit          done  = 1'b0;
  logic [31:0] model_pc;

  always #5 clk = ~clk;

  pc_branch_unit #(.RESET_VEC(RV)) dut (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .beq_i(beq_i), .bne_i(bne_i),
    .jump_i(jump_i), .jal_i(jal_i), .jreg_i(jreg_i), .zero_i(zero_i),
    .br_off_i(br_off_i), .jfield_i(jfield_i), .jreg_val_i(jreg_val_i),
    .pc_o(pc_o), .link_addr_o(link_addr_o), .link_we_o(link_we_o),
    .link_dst_o(link_dst_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] f_next(logic [31:0] pc, bit st, bit eq, bit ne,
      bit j, bit jl, bit jr, bit z, logic [15:0] off, logic [25:0] jf, logic [31:0] rv);
    logic signed [31:0] soff;
    soff = 32'(signed'(off));
    if (st) return pc;
    if (jr) return rv;
    if (j || jl) return (pc & 32'hF000_0000) | ({6'b0, jf} << 2);
    if ((eq && z) || (ne && !z)) return pc + 32'd4 + 32'(soff * 4);
    return pc + 32'd4;
  endfunction

  function automatic string f_tag(bit st, bit eq, bit ne, bit j, bit jl, bit jr, bit z);
    int n;
    n = int'(jr) + int'(j || jl) + int'(eq || ne);
    if (st) return "R8";
    if (n > 1) return "R9";
    if (jr) return "R7";
    if (j || jl) return "R5";
    if ((eq && z) || (ne && !z)) return "R3";
    if (eq || ne) return "R4";
    return "R2";
  endfunction

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input bit st, input bit eq, input bit ne, input bit j,
                      input bit jl, input bit jr, input bit z, input logic [15:0] off,
                      input logic [25:0] jf, input logic [31:0] rv);
    logic [31:0] expn;
    bit          exp_we;
    string       tag;
    stall_i = st; beq_i = eq; bne_i = ne; jump_i = j; jal_i = jl; jreg_i = jr;
    zero_i = z; br_off_i = off; jfield_i = jf; jreg_val_i = rv;
    #1;
    exp_we = !st && jl && !jr;
    tag = st ? "R8" : (jr ? "R9" : "R6");
    check(tag, "link_we", {31'b0, link_we_o}, {31'b0, exp_we});
    if (exp_we) check("R6", "link_addr", link_addr_o, model_pc + 32'd4);
    expn = f_next(model_pc, st, eq, ne, j, jl, jr, z, off, jf, rv);
    @(negedge clk);
    check(f_tag(st, eq, ne, j, jl, jr, z), "pc", pc_o, expn);
    model_pc = expn;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    stall_i = 1'b0; beq_i = 1'b0; bne_i = 1'b0; jump_i = 1'b0; jal_i = 1'b0;
    jreg_i = 1'b0; zero_i = 1'b0; br_off_i = '0; jfield_i = '0; jreg_val_i = '0;
    repeat (3) @(negedge clk);
    check("R1", "pc in reset", pc_o, RV);
    jal_i = 1'b1;
    #1;
    check("R1", "link_we in reset", {31'b0, link_we_o}, 32'd0);
    jal_i = 1'b0;
    stall_i = 1'b1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "pc after release", pc_o, RV);
    check("R6", "link_dst", {27'b0, link_dst_o}, 32'd31);
    model_pc = RV;

    // Directed corner cases.
    step(0, 0, 0, 0, 0, 0, 0, 16'h0000, 26'h0, 32'h0);          // R2
    step(0, 0, 0, 1, 0, 0, 0, 16'h0000, 26'h0000123, 32'h0);    // R5 region kept
    step(0, 0, 0, 0, 1, 0, 0, 16'h0000, 26'h3FFFFFF, 32'h0);    // R6 link
    step(0, 1, 0, 0, 0, 0, 1, 16'hFFFF, 26'h0, 32'h0);          // R3 offset -1
    step(0, 1, 0, 0, 0, 0, 0, 16'h0010, 26'h0, 32'h0);          // R4 beq not taken
    step(0, 0, 1, 0, 0, 0, 0, 16'h7FFF, 26'h0, 32'h0);          // R3 max positive
    step(0, 0, 1, 0, 0, 0, 1, 16'h0040, 26'h0, 32'h0);          // R4 bne not taken
    step(0, 0, 0, 0, 0, 1, 0, 16'h0000, 26'h0, 32'h1234_5673);  // R7 unaligned
    step(0, 1, 0, 1, 1, 1, 1, 16'h0004, 26'h55, 32'h0000_4000); // R9 jreg wins, no link
    step(0, 1, 0, 1, 0, 0, 1, 16'h0004, 26'h0000AA, 32'h0);     // R9 jump beats branch
    step(0, 1, 0, 0, 1, 0, 1, 16'h0004, 26'h000ABC, 32'h0);     // R9 jal beats branch
    step(1, 0, 0, 0, 1, 0, 0, 16'h0000, 26'h1, 32'h0);          // R8 stall with jal
    step(1, 0, 0, 0, 0, 1, 0, 16'h0000, 26'h0, 32'h8888_0000);  // R8 stall with jreg
    step(0, 0, 0, 0, 0, 1, 0, 16'h0000, 26'h0, 32'hFFFF_FFFC);  // R7
    step(0, 0, 0, 0, 0, 0, 0, 16'h0000, 26'h0, 32'h0);          // R2 wrap to 0
    step(0, 1, 0, 0, 0, 0, 1, 16'h8000, 26'h0, 32'h0);          // R3 most negative

    // Constrained random traffic.
    for (int i = 0; i < 3000; i++) begin
      bit          st, eq, ne, j, jl, jr, z;
      logic [31:0] rv;
      st = ($urandom_range(0, 9) == 0);
      jr = ($urandom_range(0, 11) == 0);
      j  = ($urandom_range(0, 11) == 0);
      jl = ($urandom_range(0, 11) == 0);
      eq = ($urandom_range(0, 4) == 0);
      ne = ($urandom_range(0, 4) == 0);
      z  = $urandom_range(0, 1) == 1;
      rv = $urandom();
      if ($urandom_range(0, 7) != 0) rv[1:0] = 2'b00;
      step(st, eq, ne, j, jl, jr, z, 16'($urandom()), 26'($urandom()), rv);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule